// File: doc/BRIEF.md
# Pattern-Watching GPIO Port Cluster

This block is a cluster of five 8-bit general-purpose I/O ports that sit on a simple byte-wide register bus. Each port has an output latch that software writes. The latch drives the data value of every pin in that port. A per-pin output-mode bit picks between an active high drive and an open-drain style release. Every pin input goes through a two-flop synchronizer. A normal read of a port returns the synchronized pin levels. A read issued with the read-modify-write qualifier returns the latch instead, so that a processor doing read, modify and write-back works on the data it last wrote and not on whatever the pins show. A per-pin input-mode bit marks a pin as analog, and that pin then reads as zero.

Ports 0, 1 and 2 each hold a mask register and a compare-value register. A port is in mismatch when its masked synchronized pins differ from its masked compare value. The OR of the three mismatches drives a wake output with no gating. It also drives an interrupt request, which is gated by an enable bit. Ports 0 to 3 accept single-bit set and clear writes in addition to byte writes. Port 4 accepts byte writes only.

Register map (5-bit address): data latch of port p at 0x00+p (p = 0..4); input mode at 0x08+p; output mode at 0x10+p; mask of port m at 0x18+m and compare value at 0x1C+m (m = 0..2); control at 0x1F, where bit 0 is the interrupt enable. Unmapped addresses read 0. Pin index of port p, bit b is p*8+b.

Top module: `gpio_match_cluster`

## Requirements
- R1: A byte write (`bus_wr_i`=1) to address 0x00+p loads `bus_wdata_i` into the latch of port p at the next clock edge. The latch appears on `pin_o[p*8+7:p*8]`.
- R2: A read of 0x00+p with `bus_rmw_i`=0 returns the synchronized pin levels of port p for digital pins, whatever the latch holds.
- R3: A read of 0x00+p with `bus_rmw_i`=1 returns the latch of port p.
- R4: A pin whose input-mode bit is 0 (analog) reads as 0 on a normal data read. Input-mode bit 1 means digital.
- R5: For each pin, a latch bit of 0 gives `pin_oe_o`=1 and `pin_o`=0. A latch bit of 1 with output-mode bit 1 gives `pin_oe_o`=1 and `pin_o`=1. A latch bit of 1 with output-mode bit 0 gives `pin_oe_o`=0.
- R6: `wake_o` is 1 exactly when, for some m in 0..2, (synchronized pins of port m AND mask m) differs from (compare value m AND mask m).
- R7: `irq_o` equals `wake_o` while control bit 0 is 1, and is 0 while it is 0.
- R8: After reset, data latches read 0xFF, input modes 0xFF, output modes 0x00, masks 0x00, compare values 0xFF, control 0x00, and `wake_o`, `irq_o` and all `pin_oe_o` bits are 0.
- R9: When `bus_bit_i`=1 and `bus_wr_i`=0, bit `bus_bit_sel_i` of the latch of port p (address 0x00+p, p = 0..3) is set to `bus_bit_val_i` and the other bits keep their values. The same access to port 4 leaves its latch unchanged.
- R10: A pin change shows on the data read and on `wake_o` after exactly two clock edges, and not after one.
- R11: `wake_o` stays 1 for as long as a masked mismatch persists, and it clears two edges after the pins stop mismatching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr_i | input | 5 | Register address |
| bus_wr_i | input | 1 | Byte write strobe |
| bus_wdata_i | input | 8 | Byte write data |
| bus_bit_i | input | 1 | Single-bit write strobe for data latches |
| bus_bit_sel_i | input | 3 | Bit position for a single-bit write |
| bus_bit_val_i | input | 1 | Value for a single-bit write |
| bus_rmw_i | input | 1 | Read-modify-write qualifier: data reads return the latch |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| pin_i | input | 40 | Pin input levels, port p bit b at p*8+b |
| pin_o | output | 40 | Pin output data |
| pin_oe_o | output | 40 | Pin output enable |
| wake_o | output | 1 | Combined mismatch event |
| irq_o | output | 1 | Mismatch event gated by the interrupt enable |

## Verification
The comparator is driven with a table of mask, compare-value and pin triples on each match-capable port. The table includes full masks with equal and with one-bit-different pins, which separates a real compare from a stuck result. It includes upper-nibble and lower-nibble masks that hide or expose the same difference, which shows that the mask bits really gate the compare. Single-bit masks check that the polarity is right. Directed tests then set the latch and the pins to different values, so that a normal read and a read-modify-write read give different answers. They also cover analog gating, all three drive states, bit writes to a bit-capable port and to the byte-only port, and the two-edge lag on both reading and event assertion and clearing.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned GRP_DATA  = 0;
  localparam int unsigned GRP_INM   = 1;
  localparam int unsigned GRP_OUTM  = 2;
  localparam int unsigned GRP_MATCH = 3;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 5'h1F;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  p_two_edge_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int unsigned PW     = 8,
  parameter bit          BIT_OK = 1'b1,
  localparam int unsigned SW    = $clog2(PW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_we,
  input  logic          inm_we,
  input  logic          outm_we,
  input  logic [PW-1:0] wdata,
  input  logic          bit_we,
  input  logic [SW-1:0] bit_sel,
  input  logic          bit_val,
  output logic [PW-1:0] latch_o,
  output logic [PW-1:0] inm_o,
  output logic [PW-1:0] outm_o,
  output logic [PW-1:0] pin_o,
  output logic [PW-1:0] pin_oe_o
);
  logic [PW-1:0] latch_q, latch_d, inm_q, outm_q;
  logic          bit_apply, latch_en;

  generate
    if (BIT_OK) begin : g_bitwr
      assign bit_apply = bit_we & ~data_we;
    end else begin : g_bytewr
      assign bit_apply = 1'b0;
      logic unused_bit;
      assign unused_bit = ^{bit_we, bit_sel, bit_val};
    end
  endgenerate

  assign latch_en = data_we | bit_apply;

  always_comb begin
    latch_d = latch_q;
    if (data_we) latch_d = wdata;
    else if (bit_apply) latch_d[bit_sel] = bit_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      inm_q   <= '1;
      outm_q  <= '0;
    end else begin
      if (latch_en) latch_q <= latch_d;
      if (inm_we)   inm_q   <= wdata;
      if (outm_we)  outm_q  <= wdata;
    end
  end

  assign latch_o  = latch_q;
  assign inm_o    = inm_q;
  assign outm_o   = outm_q;
  assign pin_o    = latch_q;
  assign pin_oe_o = ~latch_q | outm_q;

  p_byte_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> (latch_q == $past(wdata)));

  generate
    if (BIT_OK) begin : g_bit_chk
      p_bit_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_we && !data_we) |=> ($countones(latch_q ^ $past(latch_q)) <= 1));
    end else begin : g_nobit_chk
      p_bit_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_we && !data_we) |=> $stable(latch_q));
    end
  endgenerate
endmodule

// File: rtl/gpio_match.sv
module gpio_match #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_we,
  input  logic          cmp_we,
  input  logic [PW-1:0] wdata,
  input  logic [PW-1:0] pins_i,
  output logic [PW-1:0] mask_o,
  output logic [PW-1:0] cmp_o,
  output logic          miss_o
);
  logic [PW-1:0] mask_q, cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      cmp_q  <= '1;
    end else begin
      if (mask_we) mask_q <= wdata;
      if (cmp_we)  cmp_q  <= wdata;
    end
  end

  assign miss_o = |((pins_i ^ cmp_q) & mask_q);
  assign mask_o = mask_q;
  assign cmp_o  = cmp_q;

  p_mask_clear_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !miss_o);
endmodule

// File: rtl/gpio_match_cluster.sv
module gpio_match_cluster
  import gpio_pkg::*;
#(
  parameter int unsigned PW     = 8,
  parameter int unsigned NPORT  = 5,
  parameter int unsigned NMATCH = 3,
  parameter int unsigned NBIT   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [4:0]          bus_addr_i,
  input  logic                bus_wr_i,
  input  logic [7:0]          bus_wdata_i,
  input  logic                bus_bit_i,
  input  logic [2:0]          bus_bit_sel_i,
  input  logic                bus_bit_val_i,
  input  logic                bus_rmw_i,
  output logic [7:0]          bus_rdata_o,
  input  logic [NPORT*PW-1:0] pin_i,
  output logic [NPORT*PW-1:0] pin_o,
  output logic [NPORT*PW-1:0] pin_oe_o,
  output logic                wake_o,
  output logic                irq_o
);
  localparam int unsigned NPIN = NPORT * PW;
  localparam int unsigned SW   = $clog2(PW);
  localparam logic [2:0] NPORT_L  = 3'(NPORT);
  localparam logic [1:0] NMATCH_L = 2'(NMATCH);

  logic [1:0] rst_pipe_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  logic [1:0] grp;
  logic [2:0] idx;
  assign grp = bus_addr_i[4:3];
  assign idx = bus_addr_i[2:0];

  logic [NPIN-1:0] pin_sync;
  gpio_sync #(.W(NPIN)) u_sync (
    .clk(clk_i), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_sync)
  );

  logic [PW-1:0] lat_a  [NPORT];
  logic [PW-1:0] inm_a  [NPORT];
  logic [PW-1:0] outm_a [NPORT];
  logic [PW-1:0] syn_a  [NPORT];
  logic [PW-1:0] mask_a [NMATCH];
  logic [PW-1:0] cmp_a  [NMATCH];
  logic [NMATCH-1:0] miss;

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic sel;
      assign sel = (idx == 3'(p));
      assign syn_a[p] = pin_sync[p*PW +: PW];
      gpio_port #(.PW(PW), .BIT_OK(p < NBIT)) u_port (
        .clk      (clk_i),
        .rst_n    (rst_n),
        .data_we  (bus_wr_i && grp == 2'(GRP_DATA) && sel),
        .inm_we   (bus_wr_i && grp == 2'(GRP_INM)  && sel),
        .outm_we  (bus_wr_i && grp == 2'(GRP_OUTM) && sel),
        .wdata    (bus_wdata_i),
        .bit_we   (bus_bit_i && grp == 2'(GRP_DATA) && sel),
        .bit_sel  (bus_bit_sel_i[SW-1:0]),
        .bit_val  (bus_bit_val_i),
        .latch_o  (lat_a[p]),
        .inm_o    (inm_a[p]),
        .outm_o   (outm_a[p]),
        .pin_o    (pin_o[p*PW +: PW]),
        .pin_oe_o (pin_oe_o[p*PW +: PW])
      );
    end

    for (genvar m = 0; m < NMATCH; m++) begin : g_match
      logic mgrp;
      assign mgrp = bus_wr_i && grp == 2'(GRP_MATCH) && (idx[1:0] == 2'(m));
      gpio_match #(.PW(PW)) u_match (
        .clk     (clk_i),
        .rst_n   (rst_n),
        .mask_we (mgrp && !idx[2]),
        .cmp_we  (mgrp && idx[2]),
        .wdata   (bus_wdata_i),
        .pins_i  (syn_a[m]),
        .mask_o  (mask_a[m]),
        .cmp_o   (cmp_a[m]),
        .miss_o  (miss[m])
      );
    end
  endgenerate

  logic inten_q, inten_d, inten_en;
  assign inten_en = bus_wr_i && (bus_addr_i == CTRL_ADDR);
  always_comb begin
    inten_d = inten_q;
    if (inten_en) inten_d = bus_wdata_i[0];
  end
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) inten_q <= 1'b0;
    else        inten_q <= inten_d;
  end

  assign wake_o = |miss;
  assign irq_o  = wake_o & inten_q;

  always_comb begin
    bus_rdata_o = '0;
    unique case (grp)
      2'(GRP_DATA): if (idx < NPORT_L)
        bus_rdata_o = bus_rmw_i ? lat_a[idx] : (syn_a[idx] & inm_a[idx]);
      2'(GRP_INM):  if (idx < NPORT_L) bus_rdata_o = inm_a[idx];
      2'(GRP_OUTM): if (idx < NPORT_L) bus_rdata_o = outm_a[idx];
      default: begin
        if (bus_addr_i == CTRL_ADDR)       bus_rdata_o = {7'b0, inten_q};
        else if (idx[1:0] < NMATCH_L)
          bus_rdata_o = idx[2] ? cmp_a[idx[1:0]] : mask_a[idx[1:0]];
      end
    endcase
  end

  p_irq_needs_enable_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> (inten_q && wake_o));
  p_no_drive_after_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe_o == '0));
endmodule

// File: tb/tb_gpio_match_cluster.sv
`timescale 1ns/1ps
module tb_gpio_match_cluster;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  bus_addr_i = '0;
  logic        bus_wr_i = 1'b0;
  logic [7:0]  bus_wdata_i = '0;
  logic        bus_bit_i = 1'b0;
  logic [2:0]  bus_bit_sel_i = '0;
  logic        bus_bit_val_i = 1'b0;
  logic        bus_rmw_i = 1'b0;
  logic [7:0]  bus_rdata_o;
  logic [39:0] pin_i = '0;
  logic [39:0] pin_o, pin_oe_o;
  logic        wake_o, irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  gpio_match_cluster dut (.*);

  // {expect wake, port, mask, compare value, pins}
  localparam logic [27:0] VEC [9] = '{
    {1'b0, 3'd0, 8'hFF, 8'hA5, 8'hA5},
    {1'b1, 3'd0, 8'hFF, 8'hA5, 8'hA4},
    {1'b0, 3'd0, 8'hF0, 8'hA5, 8'hAF},
    {1'b1, 3'd0, 8'h0F, 8'hA5, 8'hAF},
    {1'b0, 3'd1, 8'h00, 8'h00, 8'hFF},
    {1'b0, 3'd1, 8'h80, 8'h00, 8'h7F},
    {1'b1, 3'd1, 8'h80, 8'h00, 8'h80},
    {1'b0, 3'd2, 8'h3C, 8'h24, 8'hE7},
    {1'b1, 3'd2, 8'h3C, 8'h24, 8'h2C}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic bitwr(input logic [4:0] a, input logic [2:0] b, input logic v);
    @(negedge clk_i);
    bus_addr_i = a; bus_bit_sel_i = b; bus_bit_val_i = v; bus_bit_i = 1'b1;
    @(negedge clk_i);
    bus_bit_i = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, input logic rmw, output logic [7:0] v);
    bus_addr_i = a; bus_rmw_i = rmw;
    #1;
    v = bus_rdata_o;
    bus_rmw_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic rmw, output logic [7:0] v);
    @(negedge clk_i);
    peek(a, rmw, v);
  endtask

  task automatic set_pins(input int p, input logic [7:0] v);
    @(negedge clk_i);
    pin_i[p*8 +: 8] = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R8 reset values
    rd(5'h00, 1'b1, v); chk("R8 data latch", v, 8'hFF);
    rd(5'h04, 1'b1, v); chk("R8 port4 latch", v, 8'hFF);
    rd(5'h08, 1'b0, v); chk("R8 input mode", v, 8'hFF);
    rd(5'h10, 1'b0, v); chk("R8 output mode", v, 8'h00);
    rd(5'h18, 1'b0, v); chk("R8 mask", v, 8'h00);
    rd(5'h1C, 1'b0, v); chk("R8 compare", v, 8'hFF);
    rd(5'h1F, 1'b0, v); chk("R8 control", v, 8'h00);
    chk("R8 wake", wake_o, 1'b0);
    chk("R8 irq", irq_o, 1'b0);
    chk("R8 oe", pin_oe_o, 40'h0);

    // R6 table of masked compares; R2 pins read back
    for (int i = 0; i < 9; i++) begin
      for (int m = 0; m < 3; m++) wr(5'(5'h18 + m), 8'h00);
      wr(5'(5'h18 + VEC[i][26:24]), VEC[i][23:16]);
      wr(5'(5'h1C + VEC[i][26:24]), VEC[i][15:8]);
      set_pins(int'(VEC[i][26:24]), VEC[i][7:0]);
      repeat (3) @(negedge clk_i);
      chk("R6 wake vector", wake_o, VEC[i][27]);
      chk("R7 irq disabled", irq_o, 1'b0);
      peek(5'(VEC[i][26:24]), 1'b0, v);
      chk("R2 pin read", v, VEC[i][7:0]);
    end
    for (int m = 0; m < 3; m++) wr(5'(5'h18 + m), 8'h00);

    // R1 R2 R3: latch differs from pins
    set_pins(1, 8'h00);
    wr(5'h01, 8'h3C);
    repeat (2) @(negedge clk_i);
    peek(5'h01, 1'b1, v); chk("R3 rmw read", v, 8'h3C);
    peek(5'h01, 1'b0, v); chk("R2 normal read", v, 8'h00);
    chk("R1 pin_o", pin_o[15:8], 8'h3C);

    // R5 drive modes
    wr(5'h11, 8'h0F);
    chk("R5 oe", pin_oe_o[15:8], 8'hCF);
    chk("R5 data", pin_o[15:8], 8'h3C);

    // R4 analog gating
    wr(5'h09, 8'hF0);
    set_pins(1, 8'hFF);
    repeat (2) @(negedge clk_i);
    peek(5'h01, 1'b0, v); chk("R4 analog read", v, 8'hF0);

    // R10 two-edge lag
    set_pins(3, 8'h55);
    peek(5'h03, 1'b0, v); chk("R10 lag 0 edges", v, 8'h00);
    @(negedge clk_i);
    peek(5'h03, 1'b0, v); chk("R10 lag 1 edge", v, 8'h00);
    @(negedge clk_i);
    peek(5'h03, 1'b0, v); chk("R10 lag 2 edges", v, 8'h55);

    // R9 bit writes
    bitwr(5'h03, 3'd2, 1'b0);
    rd(5'h03, 1'b1, v); chk("R9 clear bit port3", v, 8'hFB);
    bitwr(5'h03, 3'd2, 1'b1);
    rd(5'h03, 1'b1, v); chk("R9 set bit port3", v, 8'hFF);
    bitwr(5'h00, 3'd7, 1'b0);
    rd(5'h00, 1'b1, v); chk("R9 clear bit7 port0", v, 8'h7F);
    bitwr(5'h04, 3'd0, 1'b0);
    rd(5'h04, 1'b1, v); chk("R9 port4 ignores bit write", v, 8'hFF);

    // R11 level event and R10 on the event path, R7 gating
    set_pins(0, 8'h00);
    wr(5'h1C, 8'h00);
    wr(5'h18, 8'hFF);
    repeat (2) @(negedge clk_i);
    chk("R11 no mismatch", wake_o, 1'b0);
    set_pins(0, 8'h01);
    #1; chk("R10 event 0 edges", wake_o, 1'b0);
    @(negedge clk_i); #1; chk("R10 event 1 edge", wake_o, 1'b0);
    @(negedge clk_i); #1; chk("R10 event 2 edges", wake_o, 1'b1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i); #1; chk("R11 event held", wake_o, 1'b1);
    end
    wr(5'h1F, 8'h01);
    chk("R7 irq enabled", irq_o, 1'b1);
    wr(5'h1F, 8'h00);
    chk("R7 irq disabled", irq_o, 1'b0);
    chk("R7 wake ungated", wake_o, 1'b1);
    wr(5'h1F, 8'h01);
    set_pins(0, 8'h00);
    @(negedge clk_i); #1; chk("R11 held 1 edge after clear", wake_o, 1'b1);
    @(negedge clk_i); #1; chk("R11 cleared 2 edges", wake_o, 1'b0);
    chk("R7 irq follows", irq_o, 1'b0);

    finish_run();
  end
endmodule